// File: doc/BRIEF.md
# DMA Channel End-of-Transfer Strobe Generator

This block models one DMA channel as far as its end-of-transfer signalling. When it is enabled, a start pulse loads a unit count. The channel then issues one read bus cycle and one write bus cycle per unit, and each cycle waits for a completion handshake from the bus. After the last write completes, the channel raises a one-clock completion interrupt and returns to idle.

An active-low end strobe marks the end of the transfer. A 2-bit mode register chooses where the strobe falls: never, after the final read, after the final write, or together with the completion interrupt. If the transfer was requested by an on-chip peripheral rather than by software, the strobe stays high whatever the mode. The mode register accepts a write only while the channel is idle and transfer enable is low. Otherwise the write has no effect.

Top module: `dma_end_strobe`

## Requirements
- R1: The reset is synchronous and active high. It leaves the channel idle with `endStrobeN` = 1, `doneIrq` = 0 and `busActive` = 0, and it sets the mode register to 00.
- R2: A start accepted with count N > 0 produces exactly N units. Each unit is a read cycle (`busActive` = 1, `busIsWrite` = 0) followed by a write cycle (`busIsWrite` = 1). Each cycle ends on the clock edge at which `busDone` = 1.
- R3: With mode 00, `endStrobeN` stays at 1 for the whole transfer and afterwards.
- R4: With mode 01, `endStrobeN` is 0 for exactly one clock. That clock is the cycle after the edge that completes the read of the final unit.
- R5: With mode 10, `endStrobeN` is 0 for exactly one clock. That clock is the cycle after the edge that completes the write of the final unit.
- R6: With mode 11, `endStrobeN` is 0 for exactly one clock, in the same cycle as `doneIrq`.
- R7: In every mode, `doneIrq` is 1 for exactly one clock, in the cycle after the edge that completes the final write.
- R8: When `srcPeriph` = 1 at the accepted start (peripheral request), `endStrobeN` stays at 1 for that transfer in every mode. When `srcPeriph` = 0 (software request), the mode applies.
- R9: A mode write (`cfgWrEn` = 1) changes the mode only when the channel is idle and `xferEnable` = 0. Otherwise the mode is unchanged.
- R10: A start with `xferCount` = 0 produces no bus cycle, no strobe and no interrupt.
- R11: A start is accepted only while the channel is idle and `xferEnable` = 1. Any other start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xferEnable | input | 1 | Transfer enable; gates start and blocks mode writes |
| cfgWrEn | input | 1 | Mode register write request |
| cfgMode | input | 2 | Mode value to write (00 off, 01 final read, 10 final write, 11 with interrupt) |
| srcPeriph | input | 1 | Request source: 1 peripheral, 0 software; sampled at start |
| xferCount | input | CNT_W | Number of read/write units; sampled at start |
| start | input | 1 | Start pulse |
| busDone | input | 1 | Current bus cycle completes at this edge |
| busActive | output | 1 | A bus cycle is in progress |
| busIsWrite | output | 1 | Cycle type: 1 write, 0 read |
| endStrobeN | output | 1 | Active-low end-of-transfer strobe |
| doneIrq | output | 1 | One-clock completion interrupt pulse |

## Verification
Transfers of one, two and three units are run with and without bus wait states, in each mode. A one-unit transfer separates the final-read position from the final-write position. A longer transfer shows that no earlier unit is mistaken for the last. The same modes are repeated with a peripheral request source, which separates suppression of the strobe from suppression of the interrupt.

Mode writes are issued while transfers are enabled and in the middle of a transfer. The transfer that follows each of them shows whether the mode actually changed. Starts with a zero count and starts with enable low complete the set.

// File: rtl/dma_end_pkg.sv
package dma_end_pkg;

  typedef enum logic [1:0] {
    END_OFF      = 2'b00,
    END_ON_READ  = 2'b01,
    END_ON_WRITE = 2'b10,
    END_WITH_IRQ = 2'b11
  } endMode_e;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_READ  = 2'd1,
    CH_WRITE = 2'd2
  } chState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic idle;
    logic loadUnits;
    logic decUnits;
    logic finalRead;
    logic finalWrite;
  } ctrlStrobes_t;

endpackage

// File: rtl/dma_end_ctrl.sv
module dma_end_ctrl
  import dma_end_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         xferEnable,
  input  logic         reqZero,
  input  logic         unitsOne,
  input  logic         busDone,
  output ctrlStrobes_t strb,
  output logic         busActive,
  output logic         busIsWrite
);

  chState_e state, stateNext;

  always_comb begin
    strb            = '0;
    strb.idle       = (state == CH_IDLE);
    strb.loadUnits  = strb.idle && start && xferEnable && !reqZero;
    strb.finalRead  = (state == CH_READ) && busDone && unitsOne;
    strb.decUnits   = (state == CH_WRITE) && busDone;
    strb.finalWrite = strb.decUnits && unitsOne;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      CH_IDLE:  if (strb.loadUnits) stateNext = CH_READ;
      CH_READ:  if (busDone) stateNext = CH_WRITE;
      CH_WRITE: if (busDone) stateNext = unitsOne ? CH_IDLE : CH_READ;
      default:  stateNext = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= CH_IDLE;
    else     state <= stateNext;
  end

  assign busActive  = (state == CH_READ) || (state == CH_WRITE);
  assign busIsWrite = (state == CH_WRITE);

endmodule

// File: rtl/dma_end_dp.sv
module dma_end_dp
  import dma_end_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strb,
  input  logic             xferEnable,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgMode,
  input  logic             srcPeriph,
  input  logic [CNT_W-1:0] xferCount,
  output logic             reqZero,
  output logic             unitsOne,
  output endMode_e         curMode,
  output logic             periphLatched,
  output logic             endStrobeN,
  output logic             doneIrq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] unitsLeft;
  logic             hitRead, hitWrite, fireStrobe;

  assign reqZero  = (xferCount == '0);
  assign unitsOne = (unitsLeft == ONE);

  // mode register: writable only while idle with transfers disabled
  always_ff @(posedge clk) begin
    if (rst)
      curMode <= END_OFF;
    else if (cfgWrEn && strb.idle && !xferEnable)
      curMode <= endMode_e'(cfgMode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unitsLeft     <= '0;
      periphLatched <= 1'b0;
    end else if (strb.loadUnits) begin
      unitsLeft     <= xferCount;
      periphLatched <= srcPeriph;
    end else if (strb.decUnits) begin
      unitsLeft     <= unitsLeft - ONE;
    end
  end

  assign hitRead    = strb.finalRead && (curMode == END_ON_READ);
  assign hitWrite   = strb.finalWrite &&
                      ((curMode == END_ON_WRITE) || (curMode == END_WITH_IRQ));
  assign fireStrobe = !periphLatched && (hitRead || hitWrite);

  always_ff @(posedge clk) begin
    if (rst) begin
      endStrobeN <= 1'b1;
      doneIrq    <= 1'b0;
    end else begin
      endStrobeN <= !fireStrobe;
      doneIrq    <= strb.finalWrite;
    end
  end

endmodule

// File: rtl/dma_end_strobe.sv
module dma_end_strobe
  import dma_end_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xferEnable,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgMode,
  input  logic             srcPeriph,
  input  logic [CNT_W-1:0] xferCount,
  input  logic             start,
  input  logic             busDone,
  output logic             busActive,
  output logic             busIsWrite,
  output logic             endStrobeN,
  output logic             doneIrq
);

  ctrlStrobes_t strb;
  logic         reqZero, unitsOne, periphLatched;
  endMode_e     curMode;

  dma_end_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .xferEnable (xferEnable),
    .reqZero    (reqZero),
    .unitsOne   (unitsOne),
    .busDone    (busDone),
    .strb       (strb),
    .busActive  (busActive),
    .busIsWrite (busIsWrite)
  );

  dma_end_dp #(.CNT_W(CNT_W)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .strb          (strb),
    .xferEnable    (xferEnable),
    .cfgWrEn       (cfgWrEn),
    .cfgMode       (cfgMode),
    .srcPeriph     (srcPeriph),
    .xferCount     (xferCount),
    .reqZero       (reqZero),
    .unitsOne      (unitsOne),
    .curMode       (curMode),
    .periphLatched (periphLatched),
    .endStrobeN    (endStrobeN),
    .doneIrq       (doneIrq)
  );

endmodule

// File: rtl/dma_end_strobe_chk.sv
module dma_end_strobe_chk
  import dma_end_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busDone,
  input logic [CNT_W-1:0] xferCount,
  input logic             busActive,
  input logic             busIsWrite,
  input logic             endStrobeN,
  input logic             doneIrq,
  input endMode_e         curMode,
  input logic             periphLatched
);

  assert_read_then_write_R2: assert property (@(posedge clk) disable iff (rst)
    (busActive && !busIsWrite && busDone) |=> (busActive && busIsWrite));

  assert_mode_off_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (curMode == END_OFF) |-> endStrobeN);

  assert_strobe_one_clock_R4: assert property (@(posedge clk) disable iff (rst)
    !endStrobeN |=> endStrobeN);

  assert_irq_one_clock_R7: assert property (@(posedge clk) disable iff (rst)
    doneIrq |=> !doneIrq);

  assert_irq_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    doneIrq |-> $past(busActive && busIsWrite && busDone));

  assert_periph_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    periphLatched |-> endStrobeN);

  assert_mode_locked_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busActive |=> $stable(curMode));

  assert_zero_count_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (!busActive && start && xferCount == '0) |=> !busActive);

endmodule

bind dma_end_strobe dma_end_strobe_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .busDone       (busDone),
  .xferCount     (xferCount),
  .busActive     (busActive),
  .busIsWrite    (busIsWrite),
  .endStrobeN    (endStrobeN),
  .doneIrq       (doneIrq),
  .curMode       (curMode),
  .periphLatched (periphLatched)
);

// File: tb/dma_end_strobe_tb.sv
module dma_end_strobe_tb;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             xferEnable = 1'b0;
  logic             cfgWrEn = 1'b0;
  logic [1:0]       cfgMode = 2'b00;
  logic             srcPeriph = 1'b0;
  logic [CNT_W-1:0] xferCount = '0;
  logic             start = 1'b0;
  logic             busDone = 1'b0;
  logic             busActive, busIsWrite, endStrobeN, doneIrq;

  always #5 clk = ~clk;

  dma_end_strobe #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .xferEnable(xferEnable), .cfgWrEn(cfgWrEn),
    .cfgMode(cfgMode), .srcPeriph(srcPeriph), .xferCount(xferCount),
    .start(start), .busDone(busDone), .busActive(busActive),
    .busIsWrite(busIsWrite), .endStrobeN(endStrobeN), .doneIrq(doneIrq)
  );

  typedef struct {
    int    cyc;
    bit    strobeLow;
    bit    irq;
    string req;
  } evt_t;

  evt_t  expQ[$];
  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  bit    finished = 0;
  logic [1:0] modeBelief = 2'b00;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: every strobe or interrupt cycle must match the next expected event
  always @(negedge clk) begin
    if (!rst && (!endStrobeN || doneIrq)) begin
      if (expQ.size() == 0) begin
        check(0, "R3/R8", "unexpected event at cycle", cyc, -1);
      end else begin
        evt_t e;
        e = expQ.pop_front();
        check(cyc == e.cyc, e.req, "event cycle", cyc, e.cyc);
        check(!endStrobeN == e.strobeLow, e.req, "strobe low", !endStrobeN, e.strobeLow);
        check(doneIrq == e.irq, "R7", "irq", doneIrq, e.irq);
      end
    end
  end

  task automatic cfg_write(input logic [1:0] m);
    xferEnable = 1'b0;
    cfgMode = m; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    modeBelief = m;
  endtask

  task automatic serve(input bit wantWrite, input int nwait, output int doneCyc);
    while (!busActive) @(negedge clk);
    check(busIsWrite == wantWrite, "R2", "cycle type", busIsWrite, wantWrite);
    repeat (nwait) @(negedge clk);
    busDone = 1'b1;
    doneCyc = cyc;
  endtask

  task automatic run_xfer(input int count, input bit periph, input int nwait);
    int n;
    xferEnable = 1'b1;
    srcPeriph = periph; xferCount = CNT_W'(count); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int u = 0; u < count; u++) begin
      serve(1'b0, nwait, n);
      if (u == count - 1 && !periph && modeBelief == 2'b01)
        expQ.push_back('{n + 1, 1'b1, 1'b0, "R4"});
      @(negedge clk); busDone = 1'b0;
      serve(1'b1, nwait, n);
      if (u == count - 1)
        expQ.push_back('{n + 1,
          !periph && (modeBelief == 2'b10 || modeBelief == 2'b11), 1'b1,
          periph ? "R8" : (modeBelief == 2'b11 ? "R6" :
                           (modeBelief == 2'b10 ? "R5" : "R3"))});
      @(negedge clk); busDone = 1'b0;
    end
    check(!busActive, "R2", "idle after last unit", busActive, 0);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R7", "pending events", expQ.size(), 0);
  endtask

  task automatic ignored_start(input int count, input bit en, input string req);
    xferEnable = en; xferCount = CNT_W'(count); srcPeriph = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(!busActive, req, "bus active after ignored start", busActive, 0);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    check(endStrobeN == 1'b1, "R1", "strobe in reset", endStrobeN, 1);
    check(doneIrq == 1'b0, "R1", "irq in reset", doneIrq, 0);
    check(busActive == 1'b0, "R1", "bus in reset", busActive, 0);
    rst = 1'b0;
    @(negedge clk);

    run_xfer(2, 0, 0);          // R1 mode 00 after reset, R3
    cfg_write(2'b01);
    run_xfer(3, 0, 0);          // R4
    run_xfer(1, 0, 2);          // R4 single unit, wait states
    cfg_write(2'b10);
    run_xfer(1, 0, 0);          // R5
    run_xfer(2, 1, 1);          // R8 peripheral in mode 10
    cfg_write(2'b11);
    run_xfer(2, 0, 1);          // R6
    run_xfer(3, 1, 0);          // R8 peripheral in mode 11

    // R9: write while enabled is ignored
    xferEnable = 1'b1; cfgMode = 2'b00; cfgWrEn = 1'b1;
    @(negedge clk); cfgWrEn = 1'b0;
    run_xfer(1, 0, 0);          // still mode 11

    // R9: write during a transfer is ignored
    fork
      run_xfer(2, 0, 1);
      begin
        repeat (3) @(negedge clk);
        xferEnable = 1'b0; cfgMode = 2'b00; cfgWrEn = 1'b1;
        @(negedge clk);
        cfgWrEn = 1'b0; xferEnable = 1'b1;
      end
    join
    run_xfer(1, 0, 0);          // R9 mode still 11

    ignored_start(0, 1, "R10");
    ignored_start(2, 0, "R11");
    cfg_write(2'b00);
    run_xfer(1, 0, 0);          // R3 after legal write back to off

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule